// File: doc/BRIEF.md
# Paged Memory Window Controller

This block lets an 8-bit host with a 16-bit address bus reach a large external byte memory through a small 256-byte window. The window occupies host addresses 0xD600 to 0xD6FF. Two write-only host registers choose what the window shows. The page register selects one 256-byte page inside a 64 KB chunk. The bank register selects the chunk and holds the window enable.

On every enabled window access the block joins the chunk, the page and the low host address byte into a 20-bit memory address. It then drives a chip select, a write strobe and write data to a synchronous SRAM. Read data from the SRAM comes back to the host with a data-valid flag. A configuration input chooses between 16 chunks (1 MB, 4096 pages) and 4 chunks (256 KB). In the 4-chunk setting the upper chunk bits are masked, so addresses wrap inside 256 KB. Every bus master that reads the window sees the same memory.

Top module: `pmw_ctrl`

## Requirements
- R1: While `rst_n` is low, and after reset until a register is written, the page register, the chunk field and the window enable are zero, and `mem_cs`, `mem_we` and `host_rvalid` are low.
- R2: A host read or write produces a memory access only when `host_addr[15:8]` is 0xD6 and the window is enabled. The access shows as `mem_cs` high in the cycle after the request, for one cycle per request.
- R3: With `cfg_big` = 1, `mem_addr` equals {chunk[3:0], page[7:0], host_addr[7:0]}, with the chunk in bits 19:16 and the page in bits 15:8.
- R4: With `cfg_big` = 0 at the request, `mem_addr[19:18]` is zero. Chunks that differ only in bits 3:2 reach the same byte.
- R5: A write to 0xD1E0 loads all 8 bits of the page register. A write to 0xD1E2 loads the chunk from data bits 3:0 and the window enable from data bit 7. Data bits 6:4 of that write have no effect.
- R6: Each enabled window write raises `mem_we` together with `mem_cs` for exactly one cycle, with `mem_wdata` equal to the host write data.
- R7: An enabled window read raises `host_rvalid` for one cycle, two cycles after the request. `host_rdata` then carries the memory byte at the addressed location. `host_rdata` is zero whenever `host_rvalid` is low.
- R8: A read of any address outside the window, including 0xD1E0 and 0xD1E2, and any window access while the window is disabled, leaves `host_rvalid` and `mem_cs` low.
- R9: A request with `host_rd` and `host_wr` both high is treated as a write only, and no read data is returned for it.
- R10: A register write affects the next window access after it. A read already issued returns the byte at the address that was in effect when it was issued.
- R11: Writes to host addresses other than the window and the two register addresses change no register and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 16 | Host address |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read request, one per cycle |
| host_wr | input | 1 | Host write request, one per cycle |
| cfg_big | input | 1 | 1: 16 chunks (1 MB); 0: 4 chunks (256 KB) |
| host_rdata | output | 8 | Read data, zero when not valid |
| host_rvalid | output | 1 | Read data valid |
| mem_addr | output | 20 | Memory byte address |
| mem_cs | output | 1 | Memory chip select |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after a read select |

## Verification
The read return of one window access can fall in the same cycle as the memory strobe of the next access or a register update. A pipelined read is therefore still in flight when the chunk or page changes. The bench provokes this with back-to-back requests: a window read is followed at once by a bank register write and then a second window read, and window writes are mixed with window reads. A behavioural model of the register file and of memory predicts, on every clock, the select, strobe, address and returned byte. The first returned byte must match the old address and the following strobe must carry the new one.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
  typedef enum logic [1:0] {
    HIT_NONE,
    HIT_PAGE,
    HIT_BANK,
    HIT_WIN
  } hit_e;

  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic page_wr;
    logic bank_wr;
  } dec_s;
endpackage

// File: rtl/pmw_decode.sv
module pmw_decode
  import pmw_pkg::*;
#(
  parameter int HOST_AW = 16,
  parameter int OFS_W   = 8,
  parameter logic [HOST_AW-OFS_W-1:0] WIN_BASE = 8'hD6,
  parameter logic [HOST_AW-1:0] PAGE_REG = 16'hD1E0,
  parameter logic [HOST_AW-1:0] BANK_REG = 16'hD1E2
) (
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic               win_en,
  output dec_s               dec
);
  hit_e hit;

  always_comb begin
    if (host_addr[HOST_AW-1:OFS_W] == WIN_BASE) begin
      hit = HIT_WIN;
    end else if (host_addr == PAGE_REG) begin
      hit = HIT_PAGE;
    end else if (host_addr == BANK_REG) begin
      hit = HIT_BANK;
    end else begin
      hit = HIT_NONE;
    end
  end

  always_comb begin
    dec.mem_wr  = (hit == HIT_WIN) && win_en && host_wr;
    dec.mem_rd  = (hit == HIT_WIN) && win_en && host_rd && !host_wr;
    dec.page_wr = (hit == HIT_PAGE) && host_wr;
    dec.bank_wr = (hit == HIT_BANK) && host_wr;
  end
endmodule

// File: rtl/pmw_regs.sv
module pmw_regs #(
  parameter int DW      = 8,
  parameter int PAGE_W  = 8,
  parameter int CHUNK_W = 4,
  parameter int EN_BIT  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               page_wr,
  input  logic               bank_wr,
  input  logic [DW-1:0]      wdata,
  output logic [PAGE_W-1:0]  page_q,
  output logic [CHUNK_W-1:0] chunk_q,
  output logic               en_q
);
  logic [PAGE_W-1:0]  page_d;
  logic [CHUNK_W-1:0] chunk_d;
  logic               en_d;

  always_comb begin
    page_d  = page_q;
    chunk_d = chunk_q;
    en_d    = en_q;
    if (page_wr) begin
      page_d = wdata[PAGE_W-1:0];
    end
    if (bank_wr) begin
      chunk_d = wdata[CHUNK_W-1:0];
      en_d    = wdata[EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q  <= '0;
      chunk_q <= '0;
      en_q    <= 1'b0;
    end else begin
      if (page_wr) page_q <= page_d;
      if (bank_wr) begin
        chunk_q <= chunk_d;
        en_q    <= en_d;
      end
    end
  end
endmodule

// File: rtl/pmw_mempath.sv
module pmw_mempath #(
  parameter int DW       = 8,
  parameter int PAGE_W   = 8,
  parameter int CHUNK_W  = 4,
  parameter int SMALL_CW = 2,
  parameter int OFS_W    = 8,
  localparam int MEM_AW  = CHUNK_W + PAGE_W + OFS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mem_rd,
  input  logic               mem_wr,
  input  logic               cfg_big,
  input  logic [CHUNK_W-1:0] chunk,
  input  logic [PAGE_W-1:0]  page,
  input  logic [OFS_W-1:0]   offset,
  input  logic [DW-1:0]      wdata,
  input  logic [DW-1:0]      mem_rdata,
  output logic [MEM_AW-1:0]  mem_addr,
  output logic               mem_cs,
  output logic               mem_we,
  output logic [DW-1:0]      mem_wdata,
  output logic [DW-1:0]      host_rdata,
  output logic               host_rvalid
);
  logic [CHUNK_W-1:0] chunk_eff;
  logic [MEM_AW-1:0]  addr_d;
  logic               cs_d;
  logic               rv_d;

  for (genvar i = 0; i < CHUNK_W; i++) begin : g_chunk_mask
    if (i < SMALL_CW) begin : g_keep
      assign chunk_eff[i] = chunk[i];
    end else begin : g_gate
      assign chunk_eff[i] = chunk[i] & cfg_big;
    end
  end

  always_comb begin
    cs_d   = mem_rd | mem_wr;
    addr_d = {chunk_eff, page, offset};
    rv_d   = mem_cs & ~mem_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs      <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      host_rvalid <= 1'b0;
    end else begin
      mem_cs      <= cs_d;
      mem_we      <= mem_wr;
      host_rvalid <= rv_d;
      if (cs_d)   mem_addr  <= addr_d;
      if (mem_wr) mem_wdata <= wdata;
    end
  end

  assign host_rdata = host_rvalid ? mem_rdata : '0;
endmodule

// File: rtl/pmw_ctrl.sv
module pmw_ctrl
  import pmw_pkg::*;
#(
  parameter int HOST_AW  = 16,
  parameter int DW       = 8,
  parameter int OFS_W    = 8,
  parameter int PAGE_W   = 8,
  parameter int CHUNK_W  = 4,
  parameter int SMALL_CW = 2,
  parameter int EN_BIT   = 7,
  parameter logic [HOST_AW-OFS_W-1:0] WIN_BASE = 8'hD6,
  parameter logic [HOST_AW-1:0] PAGE_REG = 16'hD1E0,
  parameter logic [HOST_AW-1:0] BANK_REG = 16'hD1E2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [HOST_AW-1:0]                host_addr,
  input  logic [DW-1:0]                     host_wdata,
  input  logic                              host_rd,
  input  logic                              host_wr,
  input  logic                              cfg_big,
  output logic [DW-1:0]                     host_rdata,
  output logic                              host_rvalid,
  output logic [CHUNK_W+PAGE_W+OFS_W-1:0]   mem_addr,
  output logic                              mem_cs,
  output logic                              mem_we,
  output logic [DW-1:0]                     mem_wdata,
  input  logic [DW-1:0]                     mem_rdata
);
  dec_s               dec;
  logic [PAGE_W-1:0]  page_q;
  logic [CHUNK_W-1:0] chunk_q;
  logic               en_q;

  pmw_decode #(
    .HOST_AW(HOST_AW), .OFS_W(OFS_W), .WIN_BASE(WIN_BASE),
    .PAGE_REG(PAGE_REG), .BANK_REG(BANK_REG)
  ) u_decode (
    .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .win_en(en_q), .dec(dec)
  );

  pmw_regs #(
    .DW(DW), .PAGE_W(PAGE_W), .CHUNK_W(CHUNK_W), .EN_BIT(EN_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .page_wr(dec.page_wr), .bank_wr(dec.bank_wr),
    .wdata(host_wdata), .page_q(page_q), .chunk_q(chunk_q), .en_q(en_q)
  );

  pmw_mempath #(
    .DW(DW), .PAGE_W(PAGE_W), .CHUNK_W(CHUNK_W), .SMALL_CW(SMALL_CW), .OFS_W(OFS_W)
  ) u_mempath (
    .clk(clk), .rst_n(rst_n), .mem_rd(dec.mem_rd), .mem_wr(dec.mem_wr),
    .cfg_big(cfg_big), .chunk(chunk_q), .page(page_q),
    .offset(host_addr[OFS_W-1:0]), .wdata(host_wdata), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_cs(mem_cs), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid)
  );
endmodule

// File: rtl/pmw_checker.sv
module pmw_checker #(
  parameter int HOST_AW  = 16,
  parameter int DW       = 8,
  parameter int OFS_W    = 8,
  parameter int PAGE_W   = 8,
  parameter int CHUNK_W  = 4,
  parameter int SMALL_CW = 2,
  parameter logic [HOST_AW-OFS_W-1:0] WIN_BASE = 8'hD6,
  localparam int MEM_AW  = CHUNK_W + PAGE_W + OFS_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [HOST_AW-1:0] host_addr,
  input logic [DW-1:0]      host_wdata,
  input logic               host_rd,
  input logic               host_wr,
  input logic               cfg_big,
  input logic               host_rvalid,
  input logic [MEM_AW-1:0]  mem_addr,
  input logic               mem_cs,
  input logic               mem_we,
  input logic [DW-1:0]      mem_wdata
);
  AST_CS_FROM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs |-> $past((host_addr[HOST_AW-1:OFS_W] == WIN_BASE) && (host_rd || host_wr))); // R2

  AST_SMALL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs && $past(!cfg_big)) |-> (mem_addr[MEM_AW-1:SMALL_CW+PAGE_W+OFS_W] == '0)); // R4

  AST_WE_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_cs && $past(host_wr) && (mem_wdata == $past(host_wdata)))); // R6

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> $past(mem_cs && !mem_we)); // R7

  AST_BOTH_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs && !mem_we) |-> $past(!host_wr)); // R9
endmodule

bind pmw_ctrl pmw_checker #(
  .HOST_AW(HOST_AW), .DW(DW), .OFS_W(OFS_W), .PAGE_W(PAGE_W),
  .CHUNK_W(CHUNK_W), .SMALL_CW(SMALL_CW), .WIN_BASE(WIN_BASE)
) u_pmw_checker (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
  .host_rd(host_rd), .host_wr(host_wr), .cfg_big(cfg_big),
  .host_rvalid(host_rvalid), .mem_addr(mem_addr), .mem_cs(mem_cs),
  .mem_we(mem_we), .mem_wdata(mem_wdata)
);

// File: tb/pmw_ctrl_bench.sv
`timescale 1ns/1ps
module pmw_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic        cfg_big = 1'b1;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic [19:0] mem_addr;
  logic        mem_cs;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  pmw_ctrl u_pmw_ctrl (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_wr(host_wr), .cfg_big(cfg_big),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .mem_addr(mem_addr),
    .mem_cs(mem_cs), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // synchronous SRAM seen by the block
  logic [7:0] sram [int];
  always @(posedge clk) begin
    if (mem_cs) begin
      if (mem_we) sram[int'(mem_addr)] = mem_wdata;
      else mem_rdata <= sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 8'h00;
    end
  end

  // behavioural reference model
  logic [7:0] ref_mem [int];
  int   r_page, r_chunk, r_en;
  bit   s_cs, s_we, e_rv;
  int   s_addr, s_wd, e_rd;

  always @(posedge clk) begin
    if (!rst_n) begin
      r_page = 0; r_chunk = 0; r_en = 0;
      s_cs = 0; s_we = 0; s_addr = 0; s_wd = 0; e_rv = 0; e_rd = 0;
    end else begin
      int ch;
      e_rv = s_cs && !s_we;
      e_rd = (e_rv && ref_mem.exists(s_addr)) ? int'(ref_mem[s_addr]) : 0;
      s_cs = (r_en != 0) && (host_addr[15:8] == 8'hD6) && (host_rd || host_wr);
      s_we = s_cs && host_wr;
      ch   = cfg_big ? r_chunk : (r_chunk % 4);
      s_addr = ch * 65536 + r_page * 256 + int'(host_addr[7:0]);
      s_wd = int'(host_wdata);
      if (s_we) ref_mem[s_addr] = host_wdata;
      if (host_wr && host_addr == 16'hD1E0) r_page = int'(host_wdata);
      if (host_wr && host_addr == 16'hD1E2) begin
        r_chunk = int'(host_wdata[3:0]);
        r_en    = int'(host_wdata[7]);
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "mem_cs", int'(mem_cs), int'(s_cs));
      chk(cur_req, "mem_we", int'(mem_we), int'(s_we));
      if (s_cs) chk(cur_req, "mem_addr", int'(mem_addr), s_addr);
      if (s_we) chk(cur_req, "mem_wdata", int'(mem_wdata), s_wd);
      chk(cur_req, "host_rvalid", int'(host_rvalid), int'(e_rv));
      chk(cur_req, "host_rdata", int'(host_rdata), e_rd);
    end
  end

  task automatic op(bit rd, bit wr, logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    host_rd = rd; host_wr = wr; host_addr = a; host_wdata = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) op(1'b0, 1'b0, 16'h0000, 8'h00);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "mem_cs in reset", int'(mem_cs), 0);
    chk("R1", "mem_we in reset", int'(mem_we), 0);
    chk("R1", "host_rvalid in reset", int'(host_rvalid), 0);
    rst_n = 1'b1;
    // R1 and R8: window disabled after reset
    cur_req = "R8";
    op(1, 0, 16'hD610, 0); op(0, 1, 16'hD611, 8'h33); idle(3);
    chk("R1", "no access while disabled", int'(mem_cs), 0);
    // R5, R3, R6: enable chunk 3, page 0x12, write bytes
    cur_req = "R6";
    op(0, 1, 16'hD1E2, 8'h83); op(0, 1, 16'hD1E0, 8'h12);
    op(0, 1, 16'hD600, 8'hA5); op(0, 1, 16'hD6FF, 8'h5A); op(0, 1, 16'hD680, 8'h11);
    idle(2);
    // R7, R3: read back with exact timing
    cur_req = "R7";
    op(1, 0, 16'hD600, 0); idle(1);
    chk("R3", "read address", int'(mem_addr), 20'h312_00);
    @(negedge clk);
    chk("R7", "rvalid two cycles after read", int'(host_rvalid), 1);
    chk("R7", "read byte", int'(host_rdata), 8'hA5);
    @(negedge clk);
    chk("R7", "rdata zero when invalid", int'(host_rdata), 0);
    cur_req = "R3";
    op(1, 0, 16'hD6FF, 0); op(1, 0, 16'hD680, 0); op(1, 0, 16'hD601, 0); idle(3);
    // R5: bits 6:4 ignored, chunk from bits 3:0
    cur_req = "R5";
    op(0, 1, 16'hD1E2, 8'hF5); op(0, 1, 16'hD677, 8'hC3); idle(1);
    chk("R5", "chunk ignores bits 6:4", int'(mem_addr[19:16]), 5);
    op(1, 0, 16'hD677, 0); idle(3);
    // R4: small setting masks upper chunk bits
    cur_req = "R4";
    cfg_big = 1'b0;
    op(0, 1, 16'hD1E2, 8'h8E); op(0, 1, 16'hD1E0, 8'h40);
    op(0, 1, 16'hD605, 8'h9C); idle(1);
    chk("R4", "upper bits masked", int'(mem_addr[19:18]), 0);
    op(0, 1, 16'hD1E2, 8'h82); op(1, 0, 16'hD605, 0); idle(1);
    @(negedge clk);
    chk("R4", "alias reads same byte", int'(host_rdata), 8'h9C);
    cfg_big = 1'b1;
    op(0, 1, 16'hD1E2, 8'h8E); op(1, 0, 16'hD605, 0); op(0, 1, 16'hD605, 8'h66);
    op(1, 0, 16'hD605, 0); idle(3);
    // R9: read and write together act as write
    cur_req = "R9";
    op(1, 1, 16'hD620, 8'h4D); idle(1);
    chk("R9", "strobe on combined request", int'(mem_we), 1);
    @(negedge clk);
    chk("R9", "no read return", int'(host_rvalid), 0);
    op(1, 0, 16'hD620, 0); idle(3);
    // R10: back-to-back read, bank change, read, writes mixed with reads
    cur_req = "R10";
    op(0, 1, 16'hD1E2, 8'h83); op(0, 1, 16'hD1E0, 8'h12);
    op(1, 0, 16'hD600, 0); op(0, 1, 16'hD1E2, 8'h85);
    op(1, 0, 16'hD677, 0); op(0, 1, 16'hD1E0, 8'h13);
    op(0, 1, 16'hD600, 8'h21); op(1, 0, 16'hD600, 0); op(1, 0, 16'hD600, 0);
    idle(4);
    // R11: other addresses change nothing
    cur_req = "R11";
    op(0, 1, 16'hD1E1, 8'hFF); op(0, 1, 16'hD1E3, 8'h00); op(0, 1, 16'hD700, 8'h77);
    op(0, 1, 16'hD5FF, 8'h77); idle(1);
    chk("R11", "no strobe outside window", int'(mem_cs), 0);
    op(1, 0, 16'hD600, 0); idle(1);
    chk("R11", "page and chunk unchanged", int'(mem_addr), 20'h513_00);
    idle(2);
    // R8: register reads and outside reads give no data; disable blocks access
    cur_req = "R8";
    op(1, 0, 16'hD1E0, 0); op(1, 0, 16'hD1E2, 0); op(1, 0, 16'h1234, 0); idle(2);
    chk("R8", "no rvalid for register read", int'(host_rvalid), 0);
    op(0, 1, 16'hD1E2, 8'h05); op(0, 1, 16'hD600, 8'hEE); op(1, 0, 16'hD600, 0);
    idle(3);
    op(0, 1, 16'hD1E2, 8'h85); op(1, 0, 16'hD600, 0); idle(3);
    // R2: one select per request
    cur_req = "R2";
    op(1, 0, 16'hD6AA, 0); idle(1);
    chk("R2", "select after request", int'(mem_cs), 1);
    @(negedge clk);
    chk("R2", "select lasts one cycle", int'(mem_cs), 0);
    idle(3);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule